// File: doc/BRIEF.md
# Paged Output Over-Current Warning Threshold

This block keeps the output over-current warning threshold for both channels of a two-channel power controller. Software reaches it through a command-style write port. A page register chooses the target: channel 0, channel 1, or both at once. A threshold write is then passed through a small validation state machine. That machine either commits the value or rejects it with a NACK, and a rejection raises a communication/logic fault flag.

Each threshold is held as a 16-bit linear word. The exponent is fixed at -1, so one mantissa step equals 0.5 A. When channel 1 is set up as a slave, it has no threshold of its own: it follows channel 0, and writes aimed at it alone are refused.

A sampled output current, in 0.5 A units, is compared with the threshold of the channel it belongs to. Reaching the threshold sets sticky warning bits. Any set status bit pulls the active-low alert line low until software issues a clear.

The write state machine has four states:
- IDLE: waiting for a threshold write.
- CHECK: judging the captured word.
- COMMIT: acknowledging a stored value.
- REJECT: NACKing with a reason.

Its transitions are:
- IDLE→CHECK on a threshold write.
- CHECK→COMMIT when the verdict is good.
- CHECK→REJECT on a bad command or bad data.
- COMMIT→IDLE and REJECT→IDLE unconditionally.

Top module: `ocw_limit_regs`

## Requirements
- R1: After reset both threshold read-back words are 0xF836 (mantissa 54, 27 A), the page register is 0, every status bit is 0 and `alert_n` is 1.
- R2: The read-back words always carry exponent bits [15:11] = 5'b11111. Exponent bits in written data are ignored, and only bits [10:0] of a write are taken as the two's-complement mantissa.
- R3: Page 0x00 targets channel 0, page 0x01 targets channel 1, and page 0xFF targets both. Any other page value makes a threshold write fail with a NACK and sets the invalid-command flag (`cml_stat[7]`).
- R4: A mantissa below 4 or above 98, with negative values counted as below 4, is NACKed and sets the invalid-data flag (`cml_stat[6]`). The stored value stays unchanged.
- R5: A mantissa greater than the fault limit of any targeted channel is NACKed, sets the invalid-data flag and stores nothing. A value equal to the fault limit is accepted.
- R6: When `ch1_slave` is 1, a write with page 0x01 is NACKed, sets the invalid-command flag, and leaves both thresholds unchanged. A write with page 0xFF then updates and checks channel 0 only.
- R7: While `ch1_slave` is 1, channel 1's read-back word and its comparison threshold both equal channel 0's threshold.
- R8: A `meas_valid` sample whose `meas_cur` is greater than or equal to the effective threshold of channel `meas_ch` sets the following bits at the next clock edge:
  - that channel's `iout_stat` bit 5;
  - `stat_word[14]` (current summary);
  - `stat_word[0]` (other).
- R9: Any rejected write also sets `stat_word[1]` (communication/logic summary).
- R10: Status bits are sticky until `clr_faults`. If a set event and `clr_faults` fall in the same cycle, the new event's bits stay set and all other bits clear.
- R11: `alert_n` is 0 exactly when at least one status bit is set.
- R12: Write timing works as follows:
  - A threshold write sampled in IDLE at edge k shows `wr_ack` or `wr_nack` for the one cycle after edge k+1.
  - The new threshold is visible after edge k+1.
  - The resulting status bits appear after edge k+2.
  - A threshold write sampled outside IDLE is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| page_wr | input | 1 | Page register write strobe |
| page_din | input | 8 | Page value |
| lim_wr | input | 1 | Threshold write strobe |
| lim_din | input | 16 | Threshold word, linear format |
| ch1_slave | input | 1 | Channel 1 is configured as a slave |
| flt_lim_ch0 | input | 11 | Channel 0 fault limit mantissa |
| flt_lim_ch1 | input | 11 | Channel 1 fault limit mantissa |
| meas_valid | input | 1 | Current sample strobe |
| meas_ch | input | 1 | Channel of the sample |
| meas_cur | input | 11 | Sampled current, 0.5 A units |
| clr_faults | input | 1 | Clear all status bits |
| lim_word_ch0 | output | 16 | Channel 0 threshold word |
| lim_word_ch1 | output | 16 | Channel 1 effective threshold word |
| wr_ack | output | 1 | Write committed pulse |
| wr_nack | output | 1 | Write rejected pulse |
| iout_stat_ch0 | output | 8 | Channel 0 current status, bit 5 warning |
| iout_stat_ch1 | output | 8 | Channel 1 current status, bit 5 warning |
| stat_word | output | 16 | Summary word: bit 14 current, bit 1 comm/logic, bit 0 other |
| cml_stat | output | 8 | Bit 7 invalid command, bit 6 invalid data |
| alert_n | output | 1 | Active-low alert |

## Verification
Two cases can land in the same cycle, and the bench drives both of them deliberately. The first is a warning caused by a current sample arriving together with a `clr_faults` strobe, while other sticky bits are already set. For that case the bench expects the new warning bits to survive and every older bit to clear. The second is a rejected write whose status update lands on the same edge as a clear, which the bench judges the same way. Random writes, pages, slave changes, fault limits and samples are compared throughout against a bench model of thresholds and status.

// File: rtl/ocw_pkg.sv
package ocw_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_CHECK,
        ST_COMMIT,
        ST_REJECT
    } wr_state_e;

    typedef enum logic [1:0] {
        VD_OK,
        VD_BAD_CMD,
        VD_BAD_DATA
    } verdict_e;

    localparam int PAGE_W = 8;
    localparam logic [PAGE_W-1:0] PG_CH0 = 8'h00;
    localparam logic [PAGE_W-1:0] PG_CH1 = 8'h01;
    localparam logic [PAGE_W-1:0] PG_ALL = 8'hFF;
endpackage

// File: rtl/ocw_wr_fsm.sv
module ocw_wr_fsm
    import ocw_pkg::*;
#(
    parameter int MANT_W   = 11,
    parameter int WORD_W   = 16,
    parameter int MANT_MIN = 4,
    parameter int MANT_MAX = 98,
    parameter int MANT_DEF = 54
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              page_wr,
    input  logic [PAGE_W-1:0] page_din,
    input  logic              lim_wr,
    input  logic [WORD_W-1:0] lim_din,
    input  logic              ch1_slave,
    input  logic [MANT_W-1:0] flt_lim0,
    input  logic [MANT_W-1:0] flt_lim1,
    output logic [MANT_W-1:0] thr0_q,
    output logic [MANT_W-1:0] thr1_q,
    output logic              wr_ack,
    output logic              wr_nack,
    output logic              err_cmd,
    output logic              err_data
);
    localparam logic [MANT_W-1:0] MIN_V = MANT_W'(MANT_MIN);
    localparam logic [MANT_W-1:0] MAX_V = MANT_W'(MANT_MAX);
    localparam logic [MANT_W-1:0] DEF_V = MANT_W'(MANT_DEF);

    wr_state_e         state_q, state_d;
    verdict_e          verdict_q, verdict_d;
    logic [PAGE_W-1:0] page_q;
    logic [MANT_W-1:0] cap_q;
    logic              sel0, sel1, bad_cmd, in_rng, over;
    logic signed [MANT_W-1:0] cap_s;

    // target decode and validation
    always_comb begin
        cap_s   = cap_q;
        sel0    = (page_q == PG_CH0) || (page_q == PG_ALL);
        sel1    = (page_q == PG_CH1) || ((page_q == PG_ALL) && !ch1_slave);
        bad_cmd = !(sel0 || sel1) || ((page_q == PG_CH1) && ch1_slave);
        in_rng  = (cap_s >= $signed(MIN_V)) && (cap_s <= $signed(MAX_V));
        over    = (sel0 && (cap_q > flt_lim0)) || (sel1 && (cap_q > flt_lim1));
        if (bad_cmd)
            verdict_d = VD_BAD_CMD;
        else if (!in_rng || over)
            verdict_d = VD_BAD_DATA;
        else
            verdict_d = VD_OK;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (lim_wr) state_d = ST_CHECK;
            ST_CHECK:  state_d = (verdict_d == VD_OK) ? ST_COMMIT : ST_REJECT;
            ST_COMMIT: state_d = ST_IDLE;
            ST_REJECT: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // data registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            page_q    <= PG_CH0;
            cap_q     <= '0;
            verdict_q <= VD_OK;
            thr0_q    <= DEF_V;
            thr1_q    <= DEF_V;
        end else begin
            if (page_wr) page_q <= page_din;
            if (state_q == ST_IDLE && lim_wr) cap_q <= lim_din[MANT_W-1:0];
            if (state_q == ST_CHECK) begin
                verdict_q <= verdict_d;
                if (verdict_d == VD_OK) begin
                    if (sel0) thr0_q <= cap_q;
                    if (sel1) thr1_q <= cap_q;
                end
            end
        end
    end

    // outputs
    always_comb begin
        wr_ack   = (state_q == ST_COMMIT);
        wr_nack  = (state_q == ST_REJECT);
        err_cmd  = (state_q == ST_REJECT) && (verdict_q == VD_BAD_CMD);
        err_data = (state_q == ST_REJECT) && (verdict_q == VD_BAD_DATA);
    end

    AST_SLAVE_PAGE_NACK: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_CHECK && page_q == PG_CH1 && ch1_slave) |=> wr_nack); // R6
    AST_THR_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (thr0_q >= MIN_V && thr0_q <= MAX_V && thr1_q >= MIN_V && thr1_q <= MAX_V)); // R4
    AST_THR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_CHECK) |=> ($stable(thr0_q) && $stable(thr1_q))); // R12
    AST_ONE_RESPONSE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ack || wr_nack) |=> !(wr_ack || wr_nack)); // R12
endmodule

// File: rtl/ocw_cmp.sv
module ocw_cmp #(
    parameter int MANT_W = 11
) (
    input  logic              ch1_slave,
    input  logic [MANT_W-1:0] thr0,
    input  logic [MANT_W-1:0] thr1,
    input  logic              meas_valid,
    input  logic              meas_ch,
    input  logic [MANT_W-1:0] meas_cur,
    output logic [MANT_W-1:0] eff1,
    output logic              hit0,
    output logic              hit1
);
    always_comb begin
        eff1 = ch1_slave ? thr0 : thr1;
        hit0 = meas_valid && !meas_ch && (meas_cur >= thr0);
        hit1 = meas_valid &&  meas_ch && (meas_cur >= eff1);
    end
endmodule

// File: rtl/ocw_status.sv
module ocw_status (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clr,
    input  logic       hit0,
    input  logic       hit1,
    input  logic       err_cmd,
    input  logic       err_data,
    output logic [7:0] iout_stat0,
    output logic [7:0] iout_stat1,
    output logic [15:0] stat_word,
    output logic [7:0] cml_stat,
    output logic       alert_n
);
    localparam int NB = 4;
    logic [NB-1:0] bits_q, set_ev;

    assign set_ev = {err_data, err_cmd, hit1, hit0};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   bits_q <= '0;
        else if (clr) bits_q <= set_ev;
        else          bits_q <= bits_q | set_ev;
    end

    always_comb begin
        iout_stat0 = {2'b00, bits_q[0], 5'b00000};
        iout_stat1 = {2'b00, bits_q[1], 5'b00000};
        cml_stat   = {bits_q[2], bits_q[3], 6'b000000};
        stat_word  = {1'b0, |bits_q[1:0], 12'h000, |bits_q[3:2], |bits_q[1:0]};
        alert_n    = ~(|bits_q);
    end

    AST_OCW_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        hit0 |=> iout_stat0[5]); // R8
    AST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (iout_stat1[5] && !clr) |=> iout_stat1[5]); // R10
    AST_ALERT_ON_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        (err_cmd || err_data) |=> !alert_n); // R11
endmodule

// File: rtl/ocw_limit_regs.sv
module ocw_limit_regs
    import ocw_pkg::*;
#(
    parameter int MANT_W    = 11,
    parameter int EXP_W     = 5,
    parameter int MANT_MIN  = 4,
    parameter int MANT_MAX  = 98,
    parameter int MANT_DEF  = 54,
    parameter logic [4:0] EXP_FIXED = 5'b11111
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    page_wr,
    input  logic [7:0]              page_din,
    input  logic                    lim_wr,
    input  logic [MANT_W+EXP_W-1:0] lim_din,
    input  logic                    ch1_slave,
    input  logic [MANT_W-1:0]       flt_lim_ch0,
    input  logic [MANT_W-1:0]       flt_lim_ch1,
    input  logic                    meas_valid,
    input  logic                    meas_ch,
    input  logic [MANT_W-1:0]       meas_cur,
    input  logic                    clr_faults,
    output logic [MANT_W+EXP_W-1:0] lim_word_ch0,
    output logic [MANT_W+EXP_W-1:0] lim_word_ch1,
    output logic                    wr_ack,
    output logic                    wr_nack,
    output logic [7:0]              iout_stat_ch0,
    output logic [7:0]              iout_stat_ch1,
    output logic [15:0]             stat_word,
    output logic [7:0]              cml_stat,
    output logic                    alert_n
);
    localparam int WORD_W = MANT_W + EXP_W;

    logic [MANT_W-1:0] thr0, thr1, eff1;
    logic hit0, hit1, err_cmd, err_data;

    ocw_wr_fsm #(
        .MANT_W(MANT_W), .WORD_W(WORD_W), .MANT_MIN(MANT_MIN),
        .MANT_MAX(MANT_MAX), .MANT_DEF(MANT_DEF)
    ) u_fsm (
        .clk(clk), .rst_n(rst_n), .page_wr(page_wr), .page_din(page_din),
        .lim_wr(lim_wr), .lim_din(lim_din), .ch1_slave(ch1_slave),
        .flt_lim0(flt_lim_ch0), .flt_lim1(flt_lim_ch1),
        .thr0_q(thr0), .thr1_q(thr1), .wr_ack(wr_ack), .wr_nack(wr_nack),
        .err_cmd(err_cmd), .err_data(err_data)
    );

    ocw_cmp #(.MANT_W(MANT_W)) u_cmp (
        .ch1_slave(ch1_slave), .thr0(thr0), .thr1(thr1),
        .meas_valid(meas_valid), .meas_ch(meas_ch), .meas_cur(meas_cur),
        .eff1(eff1), .hit0(hit0), .hit1(hit1)
    );

    ocw_status u_stat (
        .clk(clk), .rst_n(rst_n), .clr(clr_faults), .hit0(hit0), .hit1(hit1),
        .err_cmd(err_cmd), .err_data(err_data),
        .iout_stat0(iout_stat_ch0), .iout_stat1(iout_stat_ch1),
        .stat_word(stat_word), .cml_stat(cml_stat), .alert_n(alert_n)
    );

    assign lim_word_ch0 = {EXP_FIXED, thr0};
    assign lim_word_ch1 = {EXP_FIXED, eff1};

    AST_ACK_NACK_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_ack && wr_nack)); // R12
    AST_SLAVE_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
        ch1_slave |-> (lim_word_ch1 == lim_word_ch0)); // R7
endmodule

// File: tb/ocw_limit_regs_bench.sv
`timescale 1ns/1ps
module ocw_limit_regs_bench;
    logic clk = 0, rst_n = 0;
    logic page_wr = 0, lim_wr = 0, ch1_slave = 0, meas_valid = 0, meas_ch = 0, clr_faults = 0;
    logic [7:0] page_din = 0;
    logic [15:0] lim_din = 0;
    logic [10:0] flt0 = 11'd100, flt1 = 11'd100, meas_cur = 0;
    logic [15:0] lw0, lw1, stat_word;
    logic wr_ack, wr_nack, alert_n;
    logic [7:0] is0, is1, cml;

    ocw_limit_regs u_ocw_limit_regs (
        .clk(clk), .rst_n(rst_n), .page_wr(page_wr), .page_din(page_din),
        .lim_wr(lim_wr), .lim_din(lim_din), .ch1_slave(ch1_slave),
        .flt_lim_ch0(flt0), .flt_lim_ch1(flt1), .meas_valid(meas_valid),
        .meas_ch(meas_ch), .meas_cur(meas_cur), .clr_faults(clr_faults),
        .lim_word_ch0(lw0), .lim_word_ch1(lw1), .wr_ack(wr_ack), .wr_nack(wr_nack),
        .iout_stat_ch0(is0), .iout_stat_ch1(is1), .stat_word(stat_word),
        .cml_stat(cml), .alert_n(alert_n)
    );

    always #5 clk = ~clk;

    int n_chk = 0, n_bad = 0, cyc = 0;
    bit done = 0;
    // model
    int m0 = 54, m1 = 54, pg = 0;
    bit o0, o1, ivc, ivd;

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !done) begin
            done = 1;
            n_chk++; n_bad++;
            $display("FAIL watchdog: act=hung exp=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    function automatic int eff1();
        return ch1_slave ? m0 : m1;
    endfunction

    // 0 ok, 1 bad command, 2 bad data
    function automatic int verdict(int mant);
        bit s0, s1;
        s0 = (pg == 0) || (pg == 255);
        s1 = (pg == 1) || (pg == 255 && !ch1_slave);
        if (!(s0 || s1) || (pg == 1 && ch1_slave)) return 1;
        if (mant < 4 || mant > 98) return 2;
        if ((s0 && mant > int'(flt0)) || (s1 && mant > int'(flt1))) return 2;
        return 0;
    endfunction

    task automatic check_all(input string tag);
        logic [15:0] ew;
        ew = 16'h0;
        ew[14] = o0 | o1; ew[1] = ivc | ivd; ew[0] = o0 | o1;
        chk(lw0 == {5'b11111, 11'(m0)}, {tag, " R2 word0"}, lw0, {5'b11111, 11'(m0)});
        chk(lw1 == {5'b11111, 11'(eff1())}, {tag, " R7 word1"}, lw1, {5'b11111, 11'(eff1())});
        chk(is0[5] == o0 && is1[5] == o1 && is0[4:0] == 0 && is1[4:0] == 0,
            {tag, " R8 iout"}, {is0, is1}, {2'b0, o0, 5'b0, 2'b0, o1, 5'b0});
        chk(stat_word == ew, {tag, " R9 status word"}, stat_word, ew);
        chk(cml == {ivc, ivd, 6'b0}, {tag, " R3 cml"}, cml, {ivc, ivd, 6'b0});
        chk(alert_n == !(o0 | o1 | ivc | ivd), {tag, " R11 alert"}, alert_n, !(o0 | o1 | ivc | ivd));
    endtask

    task automatic set_page(input int p);
        @(negedge clk) page_wr = 1; page_din = 8'(p);
        @(negedge clk) page_wr = 0;
        pg = p;
    endtask

    task automatic do_write(input logic [15:0] w, input bit clr_same);
        int mant, v;
        mant = int'($signed(w[10:0]));
        v = verdict(mant);
        @(negedge clk) lim_wr = 1; lim_din = w;
        @(negedge clk) lim_wr = 0;
        // extra strobe while busy must be ignored (R12)
        lim_wr = 1; lim_din = 16'h0000;
        @(negedge clk) lim_wr = 0;
        chk(wr_ack == (v == 0) && wr_nack == (v != 0), "R12 ack/nack", {wr_ack, wr_nack}, {v == 0, v != 0});
        if (v == 0) begin
            if (pg == 0 || pg == 255) m0 = mant;
            if (pg == 1 || (pg == 255 && !ch1_slave)) m1 = mant;
        end
        chk(lw0[10:0] == 11'(m0), "R4 R5 stored value", lw0, m0);
        if (clr_same) clr_faults = 1;
        @(negedge clk) clr_faults = 0;
        if (clr_same) begin o0 = 0; o1 = 0; ivc = 0; ivd = 0; end
        if (v == 1) ivc = 1;
        if (v == 2) ivd = 1;
        check_all("R10 write");
    endtask

    task automatic do_meas(input bit ch, input int cur, input bit clr_same);
        bit h;
        h = cur >= (ch ? eff1() : m0);
        @(negedge clk) meas_valid = 1; meas_ch = ch; meas_cur = 11'(cur); clr_faults = clr_same;
        @(negedge clk) meas_valid = 0; clr_faults = 0;
        if (clr_same) begin o0 = 0; o1 = 0; ivc = 0; ivd = 0; end
        if (h && !ch) o0 = 1;
        if (h && ch) o1 = 1;
        check_all("R8 meas");
    endtask

    task automatic do_clr();
        @(negedge clk) clr_faults = 1;
        @(negedge clk) clr_faults = 0;
        o0 = 0; o1 = 0; ivc = 0; ivd = 0;
        check_all("R10 clear");
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        chk(lw0 == 16'hF836 && lw1 == 16'hF836, "R1 reset words", {lw0, lw1}, 32'hF836F836);
        check_all("R1 reset");
        // R2 exponent ignored
        do_write(16'h0050, 0);
        chk(lw0 == 16'hF850 && lw1 == 16'hF836, "R2 page0 only", {lw0, lw1}, 32'hF850F836);
        // R4 range edges
        do_write(16'hF804, 0); do_write(16'hF862, 0);
        do_write(16'hF803, 0); do_write(16'hF863, 0); do_write(16'h07FF, 0);
        // R5 equal accepted, above rejected
        flt0 = 11'd40;
        do_write(16'hF828, 0); do_write(16'hF829, 0);
        flt0 = 11'd100;
        do_clr();
        // R3 pages
        set_page(255); do_write(16'hF820, 0);
        set_page(1); do_write(16'hF830, 0);
        set_page(7); do_write(16'hF830, 0);
        do_clr();
        // R6 slave lockout and broadcast
        ch1_slave = 1;
        set_page(1); do_write(16'hF840, 0);
        set_page(255); flt1 = 11'd5; do_write(16'hF840, 0);
        flt1 = 11'd100;
        // R7 slave comparison uses channel 0
        do_meas(1, m0 - 1, 0); do_meas(1, m0, 0);
        ch1_slave = 0;
        // R10 set and clear same cycle
        do_meas(0, m0 + 3, 1);
        set_page(9); do_write(16'hF830, 1);
        do_clr();
        // random
        for (int i = 0; i < 400; i++) begin
            int op;
            op = int'($urandom_range(0, 9));
            if (op == 0) begin
                int r;
                r = int'($urandom_range(0, 3));
                set_page(r == 0 ? 0 : r == 1 ? 1 : r == 2 ? 255 : int'($urandom_range(2, 254)));
            end else if (op <= 3) begin
                logic [15:0] w;
                w = 16'($urandom);
                if ($urandom_range(0, 3) != 0) w[10:0] = 11'($urandom_range(0, 110));
                do_write(w, $urandom_range(0, 9) == 0);
            end else if (op <= 6) begin
                bit ch;
                ch = 1'($urandom_range(0, 1));
                do_meas(ch, int'($urandom_range(0, 110)), $urandom_range(0, 7) == 0);
            end else if (op == 7) begin
                do_clr();
            end else if (op == 8) begin
                @(negedge clk) ch1_slave = 1'($urandom_range(0, 1));
                #1 check_all("R7 slave change");
            end else begin
                @(negedge clk);
                flt0 = 11'($urandom_range(0, 120));
                flt1 = 11'($urandom_range(0, 120));
            end
        end
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule